// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block buffers a stream of 9-bit words between two unrelated clock domains. A producer writes on a free-running write clock whenever both of its active-low write enables are low. A consumer reads on its own free-running read clock whenever both of its active-low read enables are low. An active-low output enable either drives the read data bus or releases it to high impedance. Reads still advance while the bus is released, so a consumer can skip words it does not need.

Four active-low status outputs report fill state: empty, full, almost-empty and almost-full. Empty and almost-empty are produced in the read clock domain. Full and almost-full are produced in the write clock domain. The two almost thresholds are held in offset registers. These are loaded over the write data bus while a load strobe is held low, and during that time the data memory is not written. Depth is set by an address-width parameter from 9 to 13 bits (512 to 8192 words). The default is 12 bits, which gives 4096 words.

Top module: `strm_fifo9`

## Requirements
- R1: After reset, empty and almost-empty are asserted (low), full and almost-full are deasserted (high), both offsets hold 7, and the read data register holds zero.
- R2: A word is stored on a write-clock rising edge only when both write enables are low, load is high and the FIFO is not full. With only one write enable low, nothing is stored.
- R3: A word is taken on a read-clock rising edge when both read enables are low and the FIFO is not empty. Words leave in write order, and each appears on the data bus after the read-clock edge that takes it.
- R4: Full asserts in the write domain on the write edge that stores word number DEPTH. Writes attempted while full are dropped and do not disturb stored data.
- R5: A read attempted while empty does not move the read pointer, and the data bus keeps its last value.
- R6: With the output enable high, the data bus is released to high impedance. Reads still advance, so the words taken during that time are skipped.
- R7: While load is low and both write enables are low, the data bus is captured into the offsets and not into memory. The first such cycle loads the almost-empty offset and the next loads the almost-full offset, alternating after that. The order restarts at almost-empty whenever load is high. Offsets are the low 9 bits of the bus.
- R8: Almost-empty is asserted while the read-domain word count is at most the almost-empty offset.
- R9: Almost-full is asserted while the write-domain free space (DEPTH minus count) is at most the almost-full offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain through a synchroniser |
| wen_a_n | input | 1 | First write enable, active low |
| wen_b_n | input | 1 | Second write enable, active low |
| ld_n | input | 1 | Offset load strobe, active low |
| din | input | 9 | Write data, or offset value during load |
| ren_a_n | input | 1 | First read enable, active low |
| ren_b_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low; high releases dout |
| dout | output | 9 | Read data, high impedance while oe_n is high |
| empty_n | output | 1 | Empty flag, active low, read domain |
| full_n | output | 1 | Full flag, active low, write domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read domain |
| afull_n | output | 1 | Almost-full flag, active low, write domain |

## Verification
The assertions assume that the offsets are quasi-static across domains: they change only while no reads are in progress, so the read domain never samples a half-updated almost-empty offset. They also assume that inputs change well clear of the edges of their own clock. The stimulus changes every input at the falling edge of its clock and loads offsets only while the FIFO is empty and idle. Before it samples a flag from the opposite domain, it waits several cycles so the synchronised pointer has settled.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;

  localparam int PTR_MAX = 14;
  typedef logic [PTR_MAX-1:0] ptr_wide_t;

  typedef enum logic {
    LD_AE = 1'b0,
    LD_AF = 1'b1
  } ld_slot_e;

  function automatic ptr_wide_t b2g(ptr_wide_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_wide_t g2b(ptr_wide_t g);
    ptr_wide_t b;
    b[PTR_MAX-1] = g[PTR_MAX-1];
    for (int i = PTR_MAX - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/dcf_sync2.sv
`timescale 1ns/1ps
module dcf_sync2 #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 9
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int                ADDR_W  = 12,
  parameter int                DATA_W  = 9,
  parameter logic [DATA_W-1:0] OFF_RST = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen_a_n,
  input  logic              wen_b_n,
  input  logic              ld_n,
  input  logic [DATA_W-1:0] din,
  input  logic [ADDR_W:0]   rgray_s,
  output logic [ADDR_W:0]   wgray,
  output logic [ADDR_W-1:0] waddr,
  output logic              push,
  output logic              full_n,
  output logic              afull_n,
  output logic [DATA_W-1:0] ae_off
);

  localparam int            PW      = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_L = PW'(1) << ADDR_W;

  logic [PW-1:0]     wbin_q, wbin_d;
  logic [PW-1:0]     wgray_q, wgray_d;
  logic [PW-1:0]     rbin;
  logic [PW-1:0]     level;
  logic [PW-1:0]     space;
  logic [DATA_W-1:0] ae_q, ae_d, af_q, af_d;
  ld_slot_e          slot_q, slot_d;
  logic              wen_both;
  logic              ld_wr;
  logic              full;

  always_comb begin
    wen_both = !wen_a_n && !wen_b_n;
    rbin     = PW'(g2b(ptr_wide_t'(rgray_s)));
    level    = wbin_q - rbin;
    space    = DEPTH_L - level;
    full     = (level == DEPTH_L);
    push     = wen_both && ld_n && !full;
    ld_wr    = wen_both && !ld_n;

    wbin_d   = push ? (wbin_q + PW'(1)) : wbin_q;
    wgray_d  = PW'(b2g(ptr_wide_t'(wbin_d)));

    ae_d     = (ld_wr && slot_q == LD_AE) ? din : ae_q;
    af_d     = (ld_wr && slot_q == LD_AF) ? din : af_q;

    if (ld_n) begin
      slot_d = LD_AE;
    end else if (ld_wr) begin
      slot_d = (slot_q == LD_AE) ? LD_AF : LD_AE;
    end else begin
      slot_d = slot_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      ae_q    <= OFF_RST;
      af_q    <= OFF_RST;
      slot_q  <= LD_AE;
    end else begin
      if (push) begin
        wbin_q  <= wbin_d;
        wgray_q <= wgray_d;
      end
      if (ld_wr) begin
        ae_q <= ae_d;
        af_q <= af_d;
      end
      slot_q <= slot_d;
    end
  end

  assign wgray   = wgray_q;
  assign waddr   = wbin_q[ADDR_W-1:0];
  assign full_n  = !full;
  assign afull_n = !(space <= PW'(af_q));
  assign ae_off  = ae_q;

  AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wbin_q != $past(wbin_q)) |-> (wbin_q == $past(wbin_q) + PW'(1))); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level <= DEPTH_L); // R4
  AST_LOAD_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_n |=> (wbin_q == $past(wbin_q))); // R7
  AST_AFULL_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !afull_n); // R9

endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ren_a_n,
  input  logic              ren_b_n,
  input  logic [ADDR_W:0]   wgray_s,
  input  logic [DATA_W-1:0] ae_off_s,
  output logic [ADDR_W:0]   rgray,
  output logic [ADDR_W-1:0] raddr,
  output logic              pop,
  output logic              empty_n,
  output logic              aempty_n
);

  localparam int            PW      = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_L = PW'(1) << ADDR_W;

  logic [PW-1:0] rbin_q, rbin_d;
  logic [PW-1:0] rgray_q, rgray_d;
  logic [PW-1:0] wbin;
  logic [PW-1:0] level;
  logic          ren_both;
  logic          empty;

  always_comb begin
    ren_both = !ren_a_n && !ren_b_n;
    wbin     = PW'(g2b(ptr_wide_t'(wgray_s)));
    level    = wbin - rbin_q;
    empty    = (level == '0);
    pop      = ren_both && !empty;
    rbin_d   = pop ? (rbin_q + PW'(1)) : rbin_q;
    rgray_d  = PW'(b2g(ptr_wide_t'(rbin_d)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (pop) begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
    end
  end

  assign rgray    = rgray_q;
  assign raddr    = rbin_q[ADDR_W-1:0];
  assign empty_n  = !empty;
  assign aempty_n = !(level <= PW'(ae_off_s));

  AST_RPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rbin_q != $past(rbin_q)) |-> (rbin_q == $past(rbin_q) + PW'(1))); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level <= DEPTH_L); // R5
  AST_EMPTY_FREEZES_RPTR: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |=> (rbin_q == $past(rbin_q))); // R5
  AST_AEMPTY_WITH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n); // R8

endmodule

// File: rtl/strm_fifo9.sv
`timescale 1ns/1ps
module strm_fifo9 #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 9
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              wen_a_n,
  input  logic              wen_b_n,
  input  logic              ld_n,
  input  logic [DATA_W-1:0] din,
  input  logic              ren_a_n,
  input  logic              ren_b_n,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout,
  output logic              empty_n,
  output logic              full_n,
  output logic              aempty_n,
  output logic              afull_n
);

  localparam int                PW      = ADDR_W + 1;
  localparam logic [DATA_W-1:0] OFF_RST = DATA_W'(7);

  logic              wrst_n, rrst_n;
  logic [PW-1:0]     wgray, wgray_s, rgray, rgray_s;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              push, pop;
  logic [DATA_W-1:0] ae_off, ae_off_s;
  logic [DATA_W-1:0] rdata;

  dcf_sync2 #(.W(1), .RST_VAL(1'b0)) u_wrst (
    .clk(wclk), .rst_n(rst_n), .d(1'b1), .q(wrst_n)
  );

  dcf_sync2 #(.W(1), .RST_VAL(1'b0)) u_rrst (
    .clk(rclk), .rst_n(rst_n), .d(1'b1), .q(rrst_n)
  );

  dcf_wr_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_RST(OFF_RST)) u_wr (
    .clk(wclk), .rst_n(wrst_n),
    .wen_a_n(wen_a_n), .wen_b_n(wen_b_n), .ld_n(ld_n), .din(din),
    .rgray_s(rgray_s), .wgray(wgray), .waddr(waddr), .push(push),
    .full_n(full_n), .afull_n(afull_n), .ae_off(ae_off)
  );

  dcf_sync2 #(.W(PW), .RST_VAL('0)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s)
  );

  dcf_sync2 #(.W(DATA_W), .RST_VAL(OFF_RST)) u_off2r (
    .clk(rclk), .rst_n(rrst_n), .d(ae_off), .q(ae_off_s)
  );

  dcf_sync2 #(.W(PW), .RST_VAL('0)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s)
  );

  dcf_rd_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(rclk), .rst_n(rrst_n),
    .ren_a_n(ren_a_n), .ren_b_n(ren_b_n),
    .wgray_s(wgray_s), .ae_off_s(ae_off_s),
    .rgray(rgray), .raddr(raddr), .pop(pop),
    .empty_n(empty_n), .aempty_n(aempty_n)
  );

  dcf_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .wclk(wclk), .we(push), .waddr(waddr), .wdata(din),
    .rclk(rclk), .rrst_n(rrst_n), .re(pop), .raddr(raddr), .rdata(rdata)
  );

  assign dout = oe_n ? {DATA_W{1'bz}} : rdata;

endmodule

// File: tb/strm_fifo9_test.sv
`timescale 1ns/1ps
module strm_fifo9_test;

  localparam int AW    = 9;
  localparam int DEPTH = 1 << AW;

  logic       wclk, rclk, rst_n;
  logic       wen_a_n, wen_b_n, ld_n, ren_a_n, ren_b_n, oe_n;
  logic [8:0] din;
  wire  [8:0] dout;
  logic       empty_n, full_n, aempty_n, afull_n;

  int n_chk, n_err, occ, wr_idx, rd_idx, ae_off, af_off;
  bit done;

  strm_fifo9 #(.ADDR_W(AW), .DATA_W(9)) uut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .wen_a_n(wen_a_n), .wen_b_n(wen_b_n), .ld_n(ld_n), .din(din),
    .ren_a_n(ren_a_n), .ren_b_n(ren_b_n), .oe_n(oe_n),
    .dout(dout), .empty_n(empty_n), .full_n(full_n),
    .aempty_n(aempty_n), .afull_n(afull_n)
  );

  initial begin
    wclk = 1'b0;
    forever #4 wclk = ~wclk;
  end

  initial begin
    rclk = 1'b0;
    #2;
    forever #4 rclk = ~rclk;
  end

  function automatic logic [8:0] pat(int i);
    return 9'((i * 37 + 5) % 512);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge wclk);
  endtask

  task automatic wr1();
    @(negedge wclk);
    wen_a_n = 1'b0; wen_b_n = 1'b0; din = pat(wr_idx);
    @(negedge wclk);
    wen_a_n = 1'b1; wen_b_n = 1'b1;
    if (occ < DEPTH) begin
      occ++; wr_idx++;
    end
  endtask

  task automatic rd1(input bit check, input string tag);
    @(negedge rclk);
    ren_a_n = 1'b0; ren_b_n = 1'b0;
    @(negedge rclk);
    ren_a_n = 1'b1; ren_b_n = 1'b1;
    if (occ > 0) begin
      if (check) chk(tag, int'(dout), int'(pat(rd_idx)));
      rd_idx++; occ--;
    end
  endtask

  task automatic ld_word(input logic [8:0] v);
    @(negedge wclk);
    ld_n = 1'b0; wen_a_n = 1'b0; wen_b_n = 1'b0; din = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    n_chk = 0; n_err = 0; occ = 0; wr_idx = 0; rd_idx = 0; done = 1'b0;
    ae_off = 7; af_off = 7;
    rst_n = 1'b0; wen_a_n = 1'b1; wen_b_n = 1'b1; ld_n = 1'b1;
    ren_a_n = 1'b1; ren_b_n = 1'b1; oe_n = 1'b0; din = '0;
    #50 rst_n = 1'b1;
    settle();

    // R1 reset state
    chk("R1 empty_n", int'(empty_n), 0);
    chk("R1 aempty_n", int'(aempty_n), 0);
    chk("R1 full_n", int'(full_n), 1);
    chk("R1 afull_n", int'(afull_n), 1);
    chk("R1 dout", int'(dout), 0);

    // R2 one enable alone stores nothing
    @(negedge wclk); wen_a_n = 1'b0; din = 9'h1AA;
    repeat (3) @(negedge wclk);
    wen_a_n = 1'b1; wen_b_n = 1'b0;
    repeat (3) @(negedge wclk);
    wen_b_n = 1'b1;
    settle();
    chk("R2 single enable", int'(empty_n), 0);

    // R8 sweep around the default almost-empty offset (R1 offset 7)
    for (int n = 1; n <= 9; n++) begin
      wr1();
      settle();
      if (n == 1) chk("R2 first word", int'(empty_n), 1);
      chk("R8 aempty default", int'(aempty_n), (occ <= ae_off) ? 0 : 1);
    end

    // R3 order of words
    for (int k = 0; k < 9; k++) rd1(1'b1, "R3 data order");
    settle();
    chk("R5 empty after drain", int'(empty_n), 0);

    // R5 read attempts while empty
    @(negedge rclk); ren_a_n = 1'b0; ren_b_n = 1'b0;
    repeat (3) @(negedge rclk);
    ren_a_n = 1'b1; ren_b_n = 1'b1;
    chk("R5 dout held", int'(dout), int'(pat(rd_idx - 1)));
    wr1();
    settle();
    rd1(1'b1, "R5 pointer unmoved");
    settle();

    // R7 offset load: AE=20, AF=30, then restart -> AE=4
    ld_word(9'd20);
    ld_word(9'd30);
    @(negedge wclk); ld_n = 1'b1; wen_a_n = 1'b1; wen_b_n = 1'b1;
    ld_word(9'd4);
    @(negedge wclk); ld_n = 1'b1; wen_a_n = 1'b1; wen_b_n = 1'b1;
    ae_off = 4; af_off = 30;
    settle();
    chk("R7 memory untouched", int'(empty_n), 0);
    for (int n = 1; n <= 6; n++) begin
      wr1();
      settle();
      chk("R7 R8 aempty loaded", int'(aempty_n), (occ <= ae_off) ? 0 : 1);
    end

    // R9 and R4 fill to full
    while (occ < DEPTH) begin
      wr1();
      if (occ >= DEPTH - 42) begin
        chk("R9 afull", int'(afull_n), ((DEPTH - occ) <= af_off) ? 0 : 1);
        chk("R4 full", int'(full_n), (occ == DEPTH) ? 0 : 1);
      end
    end
    for (int k = 0; k < 5; k++) wr1();
    chk("R4 full held", int'(full_n), 0);

    // drain with checks, release and skip on the way
    for (int k = 0; k < 40; k++) rd1(1'b1, "R4 data after overflow attempt");
    settle();
    chk("R9 afull released", int'(afull_n), 1);
    chk("R4 full released", int'(full_n), 1);
    for (int k = 0; k < 60; k++) rd1(1'b1, "R3 data order");
    oe_n = 1'b1;
    for (int k = 0; k < 3; k++) rd1(1'b0, "R6");
    @(negedge rclk); oe_n = 1'b0;
    rd1(1'b1, "R6 skipped words");
    while (occ > 0) rd1(1'b1, "R4 data after overflow attempt");
    settle();
    chk("R4 exactly depth stored", int'(empty_n), 0);
    chk("R8 aempty when empty", int'(aempty_n), 0);

    finish_run();
  end

endmodule